// File: doc/BRIEF.md
# OSD Character Raster Address Generator

This block sits between the screen timing counters and the character memories of an on-screen display. On every dot clock it takes the current dot position and raster number and works out which character cell of a 24-column by 12-row text page is under the beam. It also works out which glyph column and glyph line of that cell's 12x18 pattern is being painted. It produces the index into the 288-entry character memory, the glyph column and line, and a flag that marks the beam as inside a character. The character code that the memory returns for that index is joined with the glyph line to form the glyph-pattern memory address. A gate suppresses glyph dots for the blank code.

The page is placed through a coarse horizontal start (3-dot steps) and a coarse vertical start (2-raster steps). A programmable gap of 0 to 7 blank rasters is inserted below every row. Each row chooses its own size: normal, double height, double width, or both. A double-width row repeats every glyph column over two dots and holds only 12 characters. A double-height row repeats every glyph line over two rasters. Position, cell and memory outputs are registered, one clock after the counters. The pattern address and the dot gate combine those registered outputs with the returned code without further delay.

Top module: `osd_raster_addr`

## Requirements
- R1: While `pix_on` is high, `vram_addr` equals row*24 + column, where row is the text row (0 to 11) and column is the character position within that row counted from the left edge of the page.
- R2: In a normal-size row the glyph column runs 0 to 11 across the 12 dots of a cell and the glyph line runs 0 to 17 down the 18 rasters of a cell.
- R3: The page's left edge lies at dot `hpos`*3; dots left of it give `pix_on` low.
- R4: The page's top edge lies at raster `vpos`*2; rasters above it give `pix_on` low.
- R5: Below each row, `gap` (0 to 7) rasters follow with `pix_on` low before the next row begins.
- R6: Size field of row r is `row_size[2r+1:2r]`; bit 1 set means double width: each glyph column covers two dots, a cell is 24 dots wide and the row holds 12 characters (columns 0 to 11).
- R7: Bit 0 of a row's size field means double height: each glyph line covers two rasters and the row is 36 rasters tall before its gap.
- R8: When `char_code` is 8'hFF, `glyph_en` is low; otherwise `glyph_en` equals `pix_on`.
- R9: `cgrom_addr` is {`char_code`, `glyph_line`}, 13 bits, with the glyph line in bits 4:0.
- R10: Dots at or beyond 288 dots right of the left edge, and rasters below the gap of the last row, give `pix_on` low.
- R11: `pix_on`, `vram_addr`, `glyph_col` and `glyph_line` are registered: they reflect the counter and setting inputs sampled at the previous rising clock edge, and are all zero after a synchronous active-low reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dot_x | input | 10 | Current dot position on the line |
| line_y | input | 10 | Current raster number |
| hpos | input | 6 | Horizontal start, in 3-dot steps |
| vpos | input | 5 | Vertical start, in 2-raster steps |
| gap | input | 3 | Blank rasters inserted below every row |
| row_size | input | 24 | Two size bits per row: bit 0 tall, bit 1 wide |
| char_code | input | 8 | Code read back from character memory for `vram_addr` |
| pix_on | output | 1 | Beam is inside a character cell |
| vram_addr | output | 9 | Character memory index |
| glyph_col | output | 4 | Column within the 12-dot glyph |
| glyph_line | output | 5 | Line within the 18-raster glyph |
| cgrom_addr | output | 13 | Glyph-pattern memory address |
| glyph_en | output | 1 | Glyph dots may be shown (not blank code) |

## Verification
The bench builds the block with its default parameters: a 24x12 page of 12x18 cells, 3-dot and 2-raster start steps, 10-bit counters and a 3-bit gap. With these widths the largest start offsets (189 dots, 62 rasters) can be combined with a page of twelve double-height rows plus a 7-raster gap, 516 rasters in all. Every edge then stays inside the counter range, so the right edge, the bottom edge and all gap bands can be reached. Random counters, offsets and per-row sizes are mixed with directed probes at each edge and at the first and last dot of a doubled cell.

// File: rtl/osd_addr_pkg.sv
// Shared row-size encoding for the raster address generator.
// Assumes two size bits per row: bit 0 doubles height, bit 1 doubles width.
package osd_addr_pkg;

    typedef enum logic [1:0] {
        SZ_NORMAL = 2'b00,
        SZ_TALL   = 2'b01,
        SZ_WIDE   = 2'b10,
        SZ_BIG    = 2'b11
    } size_e;

    // True when the size field repeats each glyph line over two rasters
    function automatic logic size_tall(input logic [1:0] sz);
        return sz[0];
    endfunction

    // True when the size field repeats each glyph column over two dots
    function automatic logic size_wide(input logic [1:0] sz);
        return sz[1];
    endfunction

endpackage

// File: rtl/osd_row_locator.sv
// Maps a raster number onto a text row and glyph line.
// Rows have per-row heights (normal or doubled) plus a common gap;
// the row tops are a prefix sum built with a generate loop.
// Assumes the raster counter is wide enough for the tallest page.
module osd_row_locator #(
    parameter int ROWS   = 12,
    parameter int CELL_H = 18,
    parameter int VSTEP  = 2,
    parameter int VPOS_W = 5,
    parameter int GAP_W  = 3,
    parameter int LINE_W = 10,
    localparam int RIDX_W  = $clog2(ROWS),
    localparam int GLINE_W = $clog2(CELL_H)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LINE_W-1:0]    line_y,
    input  logic [VPOS_W-1:0]    vpos,
    input  logic [GAP_W-1:0]     gap,
    input  logic [2*ROWS-1:0]    row_size,
    output logic                 in_row,
    output logic [RIDX_W-1:0]    row_idx,
    output logic [GLINE_W-1:0]   gline,
    output logic                 row_wide
);
    import osd_addr_pkg::*;

    localparam int SPAN_W = LINE_W + 1;

    logic [SPAN_W-1:0] voff;
    logic [SPAN_W-1:0] yrel;
    logic              above;
    logic [SPAN_W-1:0] top   [ROWS];
    logic [SPAN_W-1:0] pitch [ROWS];
    logic [SPAN_W-1:0] ghgt  [ROWS];
    logic [ROWS-1:0]   hit;

    // Page top offset and raster relative to it
    assign voff  = SPAN_W'(vpos) * SPAN_W'(VSTEP);
    assign above = SPAN_W'(line_y) < voff;
    assign yrel  = SPAN_W'(line_y) - voff;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        // Glyph height and full pitch of row r
        assign ghgt[r]  = size_tall(row_size[2*r +: 2]) ? SPAN_W'(2*CELL_H) : SPAN_W'(CELL_H);
        assign pitch[r] = ghgt[r] + SPAN_W'(gap);
        if (r == 0) begin : g_first
            assign top[r] = '0;
        end else begin : g_next
            assign top[r] = top[r-1] + pitch[r-1];
        end
        // Raster falls within the pitch of row r
        assign hit[r] = !above && (yrel >= top[r]) && (yrel < top[r] + pitch[r]);
    end

    // Select the hit row and split glyph lines from the gap
    always_comb begin
        logic [SPAN_W-1:0] off;
        off      = '0;
        in_row   = 1'b0;
        row_idx  = '0;
        gline    = '0;
        row_wide = 1'b0;
        for (int r = 0; r < ROWS; r++) begin
            if (hit[r]) begin
                off      = yrel - top[r];
                row_idx  = RIDX_W'(r);
                row_wide = size_wide(row_size[2*r +: 2]);
                in_row   = off < ghgt[r];
                gline    = size_tall(row_size[2*r +: 2]) ? GLINE_W'(off >> 1) : GLINE_W'(off);
            end
        end
    end

    // R5: row bands never overlap, whatever the gap and sizes
    row_hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R2
    gline_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_row |-> (gline < GLINE_W'(CELL_H)));

endmodule

// File: rtl/osd_col_locator.sv
// Maps a dot position onto a character column and glyph column.
// Assumes the page width is the same in normal and wide rows
// (COLS normal cells or COLS/2 wide cells).
module osd_col_locator #(
    parameter int COLS   = 24,
    parameter int CELL_W = 12,
    parameter int HSTEP  = 3,
    parameter int HPOS_W = 6,
    parameter int DOT_W  = 10,
    localparam int CIDX_W = $clog2(COLS),
    localparam int GCOL_W = $clog2(CELL_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DOT_W-1:0]   dot_x,
    input  logic [HPOS_W-1:0]  hpos,
    input  logic               wide,
    output logic               in_col,
    output logic [CIDX_W-1:0]  col_idx,
    output logic [GCOL_W-1:0]  gcol
);
    localparam logic [DOT_W-1:0] SPAN   = DOT_W'(COLS * CELL_W);
    localparam logic [DOT_W-1:0] CW_N   = DOT_W'(CELL_W);
    localparam logic [DOT_W-1:0] CW_W   = DOT_W'(2 * CELL_W);

    logic [DOT_W-1:0] hoff;
    logic [DOT_W-1:0] xrel;
    logic [DOT_W-1:0] rem_n;
    logic [DOT_W-1:0] rem_w;

    // Page left offset and dot relative to it
    assign hoff = DOT_W'(hpos) * DOT_W'(HSTEP);
    assign xrel = dot_x - hoff;

    // Cell index and glyph column for both cell widths
    always_comb begin
        rem_n   = xrel % CW_N;
        rem_w   = xrel % CW_W;
        in_col  = (dot_x >= hoff) && (xrel < SPAN);
        col_idx = wide ? CIDX_W'(xrel / CW_W) : CIDX_W'(xrel / CW_N);
        gcol    = wide ? GCOL_W'(rem_w >> 1) : GCOL_W'(rem_n);
    end

    // R6
    wide_cols_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_col && wide) |-> (col_idx < CIDX_W'(COLS / 2)));

    // R2
    gcol_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_col |-> (gcol < GCOL_W'(CELL_W)));

endmodule

// File: rtl/osd_raster_addr.sv
// Top of the raster address generator: combines the row and column
// locators, registers the cell position, and forms the glyph-pattern
// address from the returned character code.
// Assumes char_code is the memory read data for the registered vram_addr.
module osd_raster_addr #(
    parameter int COLS   = 24,
    parameter int ROWS   = 12,
    parameter int CELL_W = 12,
    parameter int CELL_H = 18,
    parameter int HSTEP  = 3,
    parameter int VSTEP  = 2,
    parameter int HPOS_W = 6,
    parameter int VPOS_W = 5,
    parameter int GAP_W  = 3,
    parameter int DOT_W  = 10,
    parameter int LINE_W = 10,
    parameter int CODE_W = 8,
    localparam int ADDR_W  = $clog2(COLS * ROWS),
    localparam int GCOL_W  = $clog2(CELL_W),
    localparam int GLINE_W = $clog2(CELL_H)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DOT_W-1:0]           dot_x,
    input  logic [LINE_W-1:0]          line_y,
    input  logic [HPOS_W-1:0]          hpos,
    input  logic [VPOS_W-1:0]          vpos,
    input  logic [GAP_W-1:0]           gap,
    input  logic [2*ROWS-1:0]          row_size,
    input  logic [CODE_W-1:0]          char_code,
    output logic                       pix_on,
    output logic [ADDR_W-1:0]          vram_addr,
    output logic [GCOL_W-1:0]          glyph_col,
    output logic [GLINE_W-1:0]         glyph_line,
    output logic [CODE_W+GLINE_W-1:0]  cgrom_addr,
    output logic                       glyph_en
);
    localparam int RIDX_W = $clog2(ROWS);
    localparam int CIDX_W = $clog2(COLS);
    localparam logic [CODE_W-1:0] BLANK = '1;

    logic               in_row;
    logic               in_col;
    logic               row_wide;
    logic [RIDX_W-1:0]  row_idx;
    logic [CIDX_W-1:0]  col_idx;
    logic [GLINE_W-1:0] gline;
    logic [GCOL_W-1:0]  gcol;

    osd_row_locator #(
        .ROWS(ROWS), .CELL_H(CELL_H), .VSTEP(VSTEP),
        .VPOS_W(VPOS_W), .GAP_W(GAP_W), .LINE_W(LINE_W)
    ) u_rows (
        .clk(clk), .rst_n(rst_n), .line_y(line_y), .vpos(vpos), .gap(gap),
        .row_size(row_size), .in_row(in_row), .row_idx(row_idx),
        .gline(gline), .row_wide(row_wide)
    );

    osd_col_locator #(
        .COLS(COLS), .CELL_W(CELL_W), .HSTEP(HSTEP),
        .HPOS_W(HPOS_W), .DOT_W(DOT_W)
    ) u_cols (
        .clk(clk), .rst_n(rst_n), .dot_x(dot_x), .hpos(hpos), .wide(row_wide),
        .in_col(in_col), .col_idx(col_idx), .gcol(gcol)
    );

    // Register cell position and active flag once per dot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_on     <= 1'b0;
            vram_addr  <= '0;
            glyph_col  <= '0;
            glyph_line <= '0;
        end else begin
            pix_on     <= in_row && in_col;
            vram_addr  <= ADDR_W'(row_idx) * ADDR_W'(COLS) + ADDR_W'(col_idx);
            glyph_col  <= gcol;
            glyph_line <= gline;
        end
    end

    // Pattern address and blank-code gate from the returned code
    assign cgrom_addr = {char_code, glyph_line};
    assign glyph_en   = pix_on && (char_code != BLANK);

    // R1
    vram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_on |-> (vram_addr < ADDR_W'(COLS * ROWS)));

    // R11: nothing active the cycle after reset releases
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pix_on);

    // R8
    blank_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_on |-> !glyph_en);

endmodule

// File: tb/osd_raster_addr_test.sv
`timescale 1ns/1ps
module osd_raster_addr_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  dot_x, line_y;
    logic [5:0]  hpos;
    logic [4:0]  vpos;
    logic [2:0]  gap;
    logic [23:0] row_size;
    logic [7:0]  char_code;
    logic        pix_on, glyph_en;
    logic [8:0]  vram_addr;
    logic [3:0]  glyph_col;
    logic [4:0]  glyph_line;
    logic [12:0] cgrom_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    osd_raster_addr uut (
        .clk(clk), .rst_n(rst_n), .dot_x(dot_x), .line_y(line_y),
        .hpos(hpos), .vpos(vpos), .gap(gap), .row_size(row_size),
        .char_code(char_code), .pix_on(pix_on), .vram_addr(vram_addr),
        .glyph_col(glyph_col), .glyph_line(glyph_line),
        .cgrom_addr(cgrom_addr), .glyph_en(glyph_en)
    );

    // Reference: walk the rows top to bottom, then split the line into cells
    function automatic void model(input int x, input int y, input int h, input int v,
                                  input int g, input logic [23:0] sz,
                                  output bit on, output int addr,
                                  output int gc, output int gl);
        int yr, tp, gh, row, xr;
        bit found, wide;
        on = 0; addr = 0; gc = 0; gl = 0; found = 0; row = 0; wide = 0;
        if (y < v * 2) return;
        yr = y - v * 2;
        tp = 0;
        for (int r = 0; r < 12; r++) begin
            gh = sz[2*r] ? 36 : 18;
            if (!found && yr >= tp && yr < tp + gh) begin
                found = 1; row = r; wide = sz[2*r+1];
                gl = sz[2*r] ? (yr - tp) / 2 : yr - tp;
            end
            tp = tp + gh + g;
        end
        if (!found) return;
        if (x < h * 3) return;
        xr = x - h * 3;
        if (xr >= 288) return;
        on   = 1;
        addr = row * 24 + (wide ? xr / 24 : xr / 12);
        gc   = wide ? (xr % 24) / 2 : xr % 12;
    endfunction

    task automatic report(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Apply one probe, wait for the registered result, check it
    task automatic probe(input string req, input int x, input int y, input int h,
                         input int v, input int g, input logic [23:0] sz,
                         input logic [7:0] code);
        bit on; int addr, gc, gl;
        @(negedge clk);
        dot_x = 10'(x); line_y = 10'(y); hpos = 6'(h); vpos = 5'(v);
        gap = 3'(g); row_size = sz;
        @(negedge clk);
        char_code = code;
        #1;
        model(x, y, h, v, g, sz, on, addr, gc, gl);
        report(req, "pix_on", int'(pix_on), int'(on));
        if (on && pix_on) begin
            report(req, "vram_addr", int'(vram_addr), addr);
            report(req, "glyph_col", int'(glyph_col), gc);
            report(req, "glyph_line", int'(glyph_line), gl);
            report("R9", "cgrom_addr", int'(cgrom_addr), int'(code) * 32 + gl);
            report("R8", "glyph_en", int'(glyph_en), (code != 8'hFF) ? 1 : 0);
        end else begin
            report("R8", "glyph_en idle", int'(glyph_en), 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #3000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        rst_n = 1'b0; dot_x = 10'd100; line_y = 10'd100; hpos = '0; vpos = '0;
        gap = '0; row_size = '0; char_code = 8'h41;
        repeat (3) @(negedge clk);
        // R11 reset state, with inputs that would otherwise light the page
        report("R11", "pix_on reset", int'(pix_on), 0);
        report("R11", "vram_addr reset", int'(vram_addr), 0);
        report("R11", "glyph_line reset", int'(glyph_line), 0);
        rst_n = 1'b1;

        // R1 R2 normal page at origin
        probe("R1", 0, 0, 0, 0, 0, 24'h0, 8'h41);
        probe("R2", 287, 17, 0, 0, 0, 24'h0, 8'h42);
        probe("R1", 13, 18, 0, 0, 0, 24'h0, 8'h43);
        probe("R10", 288, 5, 0, 0, 0, 24'h0, 8'h44);
        probe("R10", 5, 216, 0, 0, 0, 24'h0, 8'h44);
        probe("R2", 150, 215, 0, 0, 0, 24'h0, 8'h45);
        // R5 gap band
        probe("R5", 10, 18, 0, 0, 5, 24'h0, 8'h46);
        probe("R5", 10, 22, 0, 0, 5, 24'h0, 8'h46);
        probe("R5", 10, 23, 0, 0, 5, 24'h0, 8'h46);
        probe("R5", 10, 22 + 23 * 11, 0, 0, 7, 24'h0, 8'h46);
        // R3 horizontal start
        probe("R3", 188, 4, 63, 0, 0, 24'h0, 8'h47);
        probe("R3", 189, 4, 63, 0, 0, 24'h0, 8'h47);
        probe("R3", 189 + 287, 4, 63, 0, 0, 24'h0, 8'h47);
        // R4 vertical start
        probe("R4", 20, 61, 0, 31, 0, 24'h0, 8'h48);
        probe("R4", 20, 62, 0, 31, 0, 24'h0, 8'h48);
        // R6 double width row 0
        probe("R6", 1, 0, 0, 0, 0, 24'h2, 8'h49);
        probe("R6", 2, 0, 0, 0, 0, 24'h2, 8'h49);
        probe("R6", 24, 0, 0, 0, 0, 24'h2, 8'h49);
        probe("R6", 287, 0, 0, 0, 0, 24'h2, 8'h49);
        // R7 double height row 0, row 1 starts at 36
        probe("R7", 0, 1, 0, 0, 0, 24'h1, 8'h4A);
        probe("R7", 0, 35, 0, 0, 0, 24'h1, 8'h4A);
        probe("R7", 0, 36, 0, 0, 0, 24'h1, 8'h4A);
        // R10 tallest page with largest offsets, last raster and one past
        probe("R10", 300, 62 + 516 - 8, 63, 31, 7, 24'hFFFFFF, 8'h4B);
        probe("R10", 300, 62 + 516 - 7, 63, 31, 7, 24'hFFFFFF, 8'h4B);
        // R8 blank code
        probe("R8", 30, 3, 0, 0, 0, 24'h0, 8'hFF);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] c;
            c = ($urandom % 8 == 0) ? 8'hFF : 8'($urandom);
            probe("R1", int'($urandom % 1024), int'($urandom % 640), int'($urandom % 64),
                  int'($urandom % 32), int'($urandom % 8), 24'($urandom), c);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule